// File: doc/BRIEF.md
# Page Permission Checker

This block guards a CPU core's path to main memory. Each load, store or instruction fetch arrives as one request carrying an address, an access width, an access kind and the requester's privilege. The block answers with one response. A grant carries the page number and the byte offset inside the page. A fault carries the offending address and the access kind. Pages are 256 bytes. Each page has a single permission byte held in a table in main memory. The table starts at a programmable base, and the entry for a page sits at base plus page number, with no scaling.

Permission bytes are read from memory over a simple request/response port, one byte read at a time. They are kept in a small direct-mapped cache indexed by the low bits of the page number. Privileged requests, or any request while checking is switched off, are granted without consulting the table. An optional strict mode faults on misaligned reads and fetches; writes are never checked for alignment.

Top module: `pgperm_checker`

## Requirements
- R1: After reset the table base is 0x00010000, checking is off, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low; enabling checking alone makes table reads start at 0x00010000.
- R2: A response reports `rsp_page` = address >> 8 and `rsp_offset` = address & 0xFF of the request it answers.
- R3: The permission byte for page P is read from byte address base + P (one byte per page, not scaled).
- R4: A privileged request, or any request while checking is off, is granted with no table read (alignment rules of R6 still apply).
- R5: Permission bytes are cached in 8 direct-mapped slots selected by page number bits [2:0]; a repeat access to a cached page issues no table read; two pages with equal low bits evict each other; `pte_release` and a base write drop every cached byte.
- R6: With `cfg_strict` high, a read (kind 0) of width 16 (size 1) at an odd address, or of width 32 (size 2) at an address not a multiple of 4, faults before any table read, privileged or not; writes are never alignment-checked; with `cfg_strict` low no alignment fault occurs.
- R7: A fetch (kind 2) is treated as a 32-bit read: it needs permission bit 0 (read) and bit 2 (execute) both set, and under strict mode it must be 4-byte aligned whatever `req_size` says.
- R8: Permission byte bit 0 allows reads (kind 0), bit 1 allows writes (kind 1), bit 2 allows execution; a zero bit for the requested kind gives a fault with `fault_addr` equal to the request address and `fault_kind` equal to the request kind.
- R9: At most one table read is outstanding; `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R10: Every accepted request gets exactly one one-cycle `rsp_valid` pulse with exactly one of `rsp_grant` and `rsp_fault` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | 0: 8 bits, 1: 16 bits, 2: 32 bits |
| req_kind | input | 2 | 0: read, 1: write, 2: fetch |
| req_priv | input | 1 | Requester is privileged |
| cfg_strict | input | 1 | Strict read alignment mode |
| en_wr | input | 1 | Load the checking-enable bit |
| en_val | input | 1 | New checking-enable value |
| base_wr | input | 1 | Load the table base (drops cache) |
| base_val | input | 32 | New table base |
| pte_release | input | 1 | Drop every cached permission byte |
| mem_req_valid | output | 1 | Table byte read request |
| mem_req_ready | input | 1 | Memory took the read |
| mem_req_addr | output | 32 | Byte address of the table read |
| mem_rsp_valid | input | 1 | Table byte returned |
| mem_rsp_data | input | 8 | Returned permission byte |
| rsp_valid | output | 1 | Response pulse |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access violation |
| rsp_page | output | 24 | Page number of the request |
| rsp_offset | output | 8 | Offset inside the page |
| fault_addr | output | 32 | Address of the refused access |
| fault_kind | output | 2 | Kind of the refused access |

## Verification
A stale or wrongly tagged cache slot shows at the ports as a missing or extra table read on the next access to that page, and may flip a grant into a fault. The bench counts table reads after every request, so such an error is caught on the very request that uses the slot. A wrong base or index computation shows as a wrong `mem_req_addr` on the first miss. A misordered decision, such as bypass before alignment, shows as a wrong grant/fault in the response two cycles after acceptance.

// File: rtl/pgperm_pkg.sv
// Shared encodings for the page permission checker.
// Assumes requests use the 2-bit kind and size codes below.
package pgperm_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_MREQ   = 2'd2,
        ST_MWAIT  = 2'd3
    } chk_state_e;

    localparam int PTE_W       = 8;
    localparam int PERM_W      = 3;
    localparam int PERM_RD_BIT = 0;
    localparam int PERM_WR_BIT = 1;
    localparam int PERM_EX_BIT = 2;
endpackage

// File: rtl/pgperm_rules.sv
// Combinational decision rules: alignment, bypass and permission match.
// Assumes the permission bits are presented for the page of the request;
// reserved kind codes are handled as plain reads.
module pgperm_rules
    import pgperm_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [1:0]        size,
    input  logic [1:0]        addr_lo,
    input  logic              strict,
    input  logic              priv,
    input  logic              chk_en,
    input  logic [PERM_W-1:0] perm,
    output logic              align_bad,
    output logic              bypass,
    output logic              perm_ok
);
    logic       is_fetch;
    logic       is_write;
    logic [1:0] eff_size;
    logic       mis;

    // Alignment: fetches count as 32-bit reads, writes are exempt.
    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        is_write = (kind == ACC_WRITE);
        eff_size = is_fetch ? SZ_WORD : size;
        case (eff_size)
            SZ_HALF: mis = addr_lo[0];
            SZ_WORD,
            SZ_RSVD: mis = |addr_lo;
            default: mis = 1'b0;
        endcase
        align_bad = strict && !is_write && mis;
    end

    // Privilege or disabled checking skips the table entirely.
    assign bypass = priv || !chk_en;

    // Permission: fetch needs read and execute, others their own bit.
    always_comb begin
        if (is_write)
            perm_ok = perm[PERM_WR_BIT];
        else if (is_fetch)
            perm_ok = perm[PERM_RD_BIT] && perm[PERM_EX_BIT];
        else
            perm_ok = perm[PERM_RD_BIT];
    end
endmodule

// File: rtl/pgperm_entry_cache.sv
// Direct-mapped cache of permission bits, one slot per low page-number value.
// Assumes a fill and a lookup refer to the same request; invalidation wins
// over a fill on the same edge.
module pgperm_entry_cache
    import pgperm_pkg::*;
#(
    parameter int PIDX_W = 24,
    parameter int SLOTS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic [PIDX_W-1:0] lookup_idx,
    output logic              hit,
    output logic [PERM_W-1:0] hit_perm,
    input  logic              fill_en,
    input  logic [PIDX_W-1:0] fill_idx,
    input  logic [PERM_W-1:0] fill_perm
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int TAG_W  = PIDX_W - SLOT_W;

    logic [SLOTS-1:0]  slot_vld;
    logic [TAG_W-1:0]  slot_tag  [SLOTS];
    logic [PERM_W-1:0] slot_perm [SLOTS];

    logic [SLOT_W-1:0] lk_slot;
    logic [SLOT_W-1:0] fl_slot;
    assign lk_slot = lookup_idx[SLOT_W-1:0];
    assign fl_slot = fill_idx[SLOT_W-1:0];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [PERM_W-1:0] p_q;

        // Slot storage: cleared on reset or invalidate, loaded on a fill.
        always_ff @(posedge clk) begin
            if (!rst_n || inv) begin
                v_q <= 1'b0;
                t_q <= '0;
                p_q <= '0;
            end else if (fill_en && fl_slot == SLOT_W'(s)) begin
                v_q <= 1'b1;
                t_q <= fill_idx[PIDX_W-1:SLOT_W];
                p_q <= fill_perm;
            end
        end

        assign slot_vld[s]  = v_q;
        assign slot_tag[s]  = t_q;
        assign slot_perm[s] = p_q;
    end

    // Lookup: valid slot with a matching tag.
    assign hit      = slot_vld[lk_slot] && (slot_tag[lk_slot] == lookup_idx[PIDX_W-1:SLOT_W]);
    assign hit_perm = slot_perm[lk_slot];

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv) |-> !hit); // R5
    AST_FILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en) && !$past(inv) && lookup_idx == $past(fill_idx)) |-> hit); // R5
endmodule

// File: rtl/pgperm_checker.sv
// Page permission checker between a CPU core and memory.
// Takes one request at a time, decides grant or fault, fetching a page's
// permission byte from the in-memory table on a cache miss.
// Assumes memory answers each byte read exactly once, after the request.
module pgperm_checker
    import pgperm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 8,
    parameter int CACHE_SLOTS = 8,
    parameter logic [ADDR_W-1:0] PT_BASE_RST = 32'h0001_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic [1:0]               req_kind,
    input  logic                     req_priv,
    input  logic                     cfg_strict,
    input  logic                     en_wr,
    input  logic                     en_val,
    input  logic                     base_wr,
    input  logic [ADDR_W-1:0]        base_val,
    input  logic                     pte_release,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [ADDR_W-1:0]        mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [PTE_W-1:0]         mem_rsp_data,
    output logic                     rsp_valid,
    output logic                     rsp_grant,
    output logic                     rsp_fault,
    output logic [ADDR_W-PAGE_SHIFT-1:0] rsp_page,
    output logic [PAGE_SHIFT-1:0]    rsp_offset,
    output logic [ADDR_W-1:0]        fault_addr,
    output logic [1:0]               fault_kind
);
    localparam int PIDX_W = ADDR_W - PAGE_SHIFT;

    chk_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [1:0]        kind_q;
    logic              priv_q;
    logic              strict_q;
    logic              use_fill_q;
    logic [PERM_W-1:0] fill_q;
    logic              kill_q;
    logic [ADDR_W-1:0] base_q;
    logic              en_q;
    logic [ADDR_W-1:0] maddr_q;
    logic              rsp_valid_q;
    logic              rsp_grant_q;

    logic [PIDX_W-1:0] req_idx;
    logic [ADDR_W-1:0] entry_addr;
    logic              inv;
    logic              hit;
    logic [PERM_W-1:0] hit_perm;
    logic [PERM_W-1:0] perm_sel;
    logic              fill_en;
    logic              align_bad;
    logic              bypass;
    logic              perm_ok;
    logic              decide_grant;
    logic              resolved;
    logic              unused_hi;

    assign req_idx    = addr_q[ADDR_W-1:PAGE_SHIFT];
    assign entry_addr = base_q + {{PAGE_SHIFT{1'b0}}, req_idx};
    assign inv        = pte_release || base_wr;
    assign perm_sel   = use_fill_q ? fill_q : hit_perm;
    assign unused_hi  = ^mem_rsp_data[PTE_W-1:PERM_W];
    assign fill_en    = (state_q == ST_MWAIT) && mem_rsp_valid && !kill_q;

    // Configuration registers: table base and checking enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= PT_BASE_RST;
            en_q   <= 1'b0;
        end else begin
            if (base_wr) base_q <= base_val;
            if (en_wr)   en_q   <= en_val;
        end
    end

    pgperm_entry_cache #(
        .PIDX_W (PIDX_W),
        .SLOTS  (CACHE_SLOTS)
    ) cache_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv        (inv),
        .lookup_idx (req_idx),
        .hit        (hit),
        .hit_perm   (hit_perm),
        .fill_en    (fill_en),
        .fill_idx   (req_idx),
        .fill_perm  (mem_rsp_data[PERM_W-1:0])
    );

    pgperm_rules rules_i (
        .kind      (kind_q),
        .size      (size_q),
        .addr_lo   (addr_q[1:0]),
        .strict    (strict_q),
        .priv      (priv_q),
        .chk_en    (en_q),
        .perm      (perm_sel),
        .align_bad (align_bad),
        .bypass    (bypass),
        .perm_ok   (perm_ok)
    );

    // Decision order: alignment first, then bypass, then table bits.
    assign decide_grant = !align_bad && (bypass || perm_ok);
    assign resolved     = align_bad || bypass || use_fill_q || hit;

    // Request sequencer: accept, decide, fetch a table byte on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            size_q      <= '0;
            kind_q      <= '0;
            priv_q      <= 1'b0;
            strict_q    <= 1'b0;
            use_fill_q  <= 1'b0;
            fill_q      <= '0;
            kill_q      <= 1'b0;
            maddr_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_grant_q <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (inv && (state_q == ST_MREQ || state_q == ST_MWAIT))
                kill_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q     <= req_addr;
                        size_q     <= req_size;
                        kind_q     <= req_kind;
                        priv_q     <= req_priv;
                        strict_q   <= cfg_strict;
                        use_fill_q <= 1'b0;
                        kill_q     <= 1'b0;
                        state_q    <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (resolved) begin
                        rsp_valid_q <= 1'b1;
                        rsp_grant_q <= decide_grant;
                        state_q     <= ST_IDLE;
                    end else begin
                        maddr_q <= entry_addr;
                        state_q <= ST_MREQ;
                    end
                end
                ST_MREQ: begin
                    if (mem_req_ready)
                        state_q <= ST_MWAIT;
                end
                ST_MWAIT: begin
                    if (mem_rsp_valid) begin
                        fill_q     <= mem_rsp_data[PERM_W-1:0];
                        use_fill_q <= 1'b1;
                        state_q    <= ST_DECIDE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_MREQ);
    assign mem_req_addr  = maddr_q;
    assign rsp_valid     = rsp_valid_q;
    assign rsp_grant     = rsp_valid_q && rsp_grant_q;
    assign rsp_fault     = rsp_valid_q && !rsp_grant_q;
    assign rsp_page      = addr_q[ADDR_W-1:PAGE_SHIFT];
    assign rsp_offset    = addr_q[PAGE_SHIFT-1:0];
    assign fault_addr    = addr_q;
    assign fault_kind    = kind_q;

    AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
    AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_grant, rsp_fault})); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_BYPASS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !align_bad && bypass) |=> (rsp_valid && rsp_grant && !mem_req_valid)); // R4
    AST_ALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && align_bad) |=> (rsp_valid && rsp_fault)); // R6
endmodule

// File: tb/pgperm_checker_tb_top.sv
// Scoreboard bench: the driver queues expected outcomes, a monitor pops
// and compares them; a memory model serves permission-table byte reads.
module pgperm_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        cfg_strict = 1'b0;
    logic        en_wr = 1'b0;
    logic        en_val = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_val = '0;
    logic        pte_release = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [7:0]  mem_rsp_data;
    logic        rsp_valid, rsp_grant, rsp_fault;
    logic [23:0] rsp_page;
    logic [7:0]  rsp_offset;
    logic [31:0] fault_addr;
    logic [1:0]  fault_kind;

    always #2 clk = ~clk;

    pgperm_checker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_kind(req_kind), .req_priv(req_priv),
        .cfg_strict(cfg_strict), .en_wr(en_wr), .en_val(en_val),
        .base_wr(base_wr), .base_val(base_val), .pte_release(pte_release),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_fault(rsp_fault), .rsp_page(rsp_page), .rsp_offset(rsp_offset),
        .fault_addr(fault_addr), .fault_kind(fault_kind)
    );

    typedef struct {
        logic        grant;
        logic [31:0] addr;
        logic [1:0]  kind;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_err = 0;
    int          rd_cnt = 0;
    logic [31:0] last_rd = '0;
    logic [7:0]  pte_mem [256];
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(rsp_grant === e.grant, e.req, "grant", {31'd0, rsp_grant}, {31'd0, e.grant});
                check((rsp_grant ^ rsp_fault) === 1'b1, "R10", "grant xor fault",
                      {30'd0, rsp_grant, rsp_fault}, {30'd0, e.grant, !e.grant});
                check(rsp_page === e.addr[31:8], "R2", "page", {8'd0, rsp_page}, {8'd0, e.addr[31:8]});
                check(rsp_offset === e.addr[7:0], "R2", "offset", {24'd0, rsp_offset}, {24'd0, e.addr[7:0]});
                if (!e.grant) begin
                    check(fault_addr === e.addr, "R8", "fault_addr", fault_addr, e.addr);
                    check(fault_kind === e.kind, "R8", "fault_kind", {30'd0, fault_kind}, {30'd0, e.kind});
                end
            end
        end
    end

    // Memory model: one read at a time, ready one cycle late, data two later.
    initial begin
        logic [31:0] a0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                a0 = mem_req_addr;
                @(negedge clk);
                check(mem_req_valid && mem_req_addr === a0, "R9", "request held", mem_req_addr, a0);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                rd_cnt++;
                last_rd = a0;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte_mem[a0[7:0]];
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Driver: queue the expectation, hand the request over, wait for the answer.
    task automatic issue(input logic [31:0] addr, input logic [1:0] size, input logic [1:0] kind,
                         input logic priv, input logic grant, input string req);
        exp_t e;
        e.grant = grant; e.addr = addr; e.kind = kind; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = size; req_kind = kind; req_priv = priv;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic reads_are(input int n, input string req);
        check(rd_cnt == n, req, "table read count", rd_cnt, n);
    endtask

    task automatic pulse_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_val = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pte_mem[i] = 8'h00;
        pte_mem[8'h03] = 8'b001;   // page 3: read only
        pte_mem[8'h05] = 8'b101;   // page 5: read + execute
        pte_mem[8'h06] = 8'b100;   // page 6: execute only
        pte_mem[8'h0B] = 8'b010;   // page 0xB: write only
        pte_mem[8'h43] = 8'b000;   // page 3 under the second base
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1, "R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
        // R4 / R1: checking off after reset, unprivileged write granted
        issue(32'h1234_5678, 2'd2, 2'd1, 1'b0, 1'b1, "R4");
        reads_are(0, "R4");
        pulse_en(1'b1);
        // R1 / R3: default base, byte read of page 3
        issue(32'h0000_0312, 2'd0, 2'd0, 1'b0, 1'b1, "R8");
        reads_are(1, "R3");
        check(last_rd === 32'h0001_0003, "R1", "table address", last_rd, 32'h0001_0003);
        // R8 / R5: write refused using cached byte
        issue(32'h0000_0300, 2'd2, 2'd1, 1'b0, 1'b0, "R8");
        reads_are(1, "R5");
        // R7: fetch without execute bit
        issue(32'h0000_0304, 2'd2, 2'd2, 1'b0, 1'b0, "R7");
        issue(32'h0000_0500, 2'd2, 2'd2, 1'b0, 1'b1, "R7");
        check(last_rd === 32'h0001_0005, "R3", "table address page 5", last_rd, 32'h0001_0005);
        issue(32'h0000_0600, 2'd2, 2'd2, 1'b0, 1'b0, "R7");
        reads_are(3, "R7");
        // R4: privileged write ignores the table
        issue(32'h0000_0300, 2'd2, 2'd1, 1'b1, 1'b1, "R4");
        reads_are(3, "R4");
        // R5: release forces a re-read
        @(negedge clk); pte_release = 1'b1;
        @(negedge clk); pte_release = 1'b0;
        issue(32'h0000_0312, 2'd0, 2'd0, 1'b0, 1'b1, "R5");
        reads_are(4, "R5");
        // R5: page 0xB shares slot 3 with page 3
        issue(32'h0000_0B00, 2'd2, 2'd1, 1'b0, 1'b1, "R8");
        reads_are(5, "R5");
        issue(32'h0000_0312, 2'd0, 2'd0, 1'b0, 1'b1, "R5");
        reads_are(6, "R5");
        // R6: strict alignment
        cfg_strict = 1'b1;
        issue(32'h0000_0313, 2'd1, 2'd0, 1'b0, 1'b0, "R6");
        issue(32'h0000_0312, 2'd2, 2'd0, 1'b0, 1'b0, "R6");
        reads_are(6, "R6");
        issue(32'h0000_0314, 2'd2, 2'd0, 1'b0, 1'b1, "R6");
        issue(32'h0000_0312, 2'd1, 2'd0, 1'b0, 1'b1, "R6");
        issue(32'h0000_0B01, 2'd2, 2'd1, 1'b0, 1'b1, "R6");
        reads_are(7, "R5");
        issue(32'h0000_0001, 2'd1, 2'd0, 1'b1, 1'b0, "R6");
        issue(32'h0000_0502, 2'd0, 2'd2, 1'b0, 1'b0, "R7");
        reads_are(7, "R6");
        cfg_strict = 1'b0;
        issue(32'h0000_0313, 2'd1, 2'd0, 1'b0, 1'b1, "R6");
        reads_are(8, "R6");
        // R3 / R5: new base drops the cache, entry at base + page
        @(negedge clk); base_wr = 1'b1; base_val = 32'h0002_0040;
        @(negedge clk); base_wr = 1'b0;
        issue(32'h0000_0312, 2'd0, 2'd0, 1'b0, 1'b0, "R8");
        reads_are(9, "R5");
        check(last_rd === 32'h0002_0043, "R3", "table address new base", last_rd, 32'h0002_0043);
        // R4: checking off again
        pulse_en(1'b0);
        issue(32'h0000_0312, 2'd0, 2'd0, 1'b0, 1'b1, "R4");
        reads_are(9, "R4");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending responses", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog expired: actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule